// File: doc/BRIEF.md
# Interrupt Destination Match Mask Generator

This block decides which local interrupt controllers an interrupt routing entry is aimed at. A request carries an 8-bit destination value and a mode bit. For each of up to eight attached targets the block also sees a physical identifier, a logical destination register and a destination format register. A count says how many of the target slots are populated. One cycle after a request strobe, the block returns an 8-bit delivery mask, a valid pulse and a flag that is set when no target was selected.

There are two addressing modes. In physical mode the destination is compared for equality with each target's identifier, and only the lowest-index match is reported. In logical mode each target is checked under its own addressing model, chosen by the top nibble of its format register. A flat target matches on any overlap between the destination and its 8-bit logical field. A cluster target must have the same cluster number in the upper nibble and at least one common member bit in the lower nibble. Every target that matches in logical mode is reported.

The block only produces the mask. Choosing one target from several, and injecting the interrupt, belong to later stages.

Top module: `dest_match_gen`

## Requirements
- R1: With `logical_mode_i`=0, `mask_o` has only bit i set, where i is the lowest present index whose `tgt_phys_id_i[8i+7:8i]` equals `dest_i`. If no present target has that identifier, `mask_o` is zero.
- R2: With `logical_mode_i`=1 and `dest_i`=0, `mask_o` is zero whatever the target registers hold.
- R3: In logical mode, a target whose format bits [31:28] are 4'hF (flat) matches when `dest_i` AND its logical register bits [31:24] is nonzero.
- R4: In logical mode, a target whose format bits [31:28] are 4'h0 (cluster) matches when its logical register bits [31:28] equal `dest_i[7:4]` and its logical register bits [27:24] AND `dest_i[3:0]` is nonzero.
- R5: In logical mode, every matching present target sets its own bit, so several bits may be set at once.
- R6: A target whose index i is not below `tgt_count_i` never sets a bit in either mode. A count above 8 makes all eight slots present.
- R7: In logical mode, a target whose format bits [31:28] are neither 4'hF nor 4'h0 never matches.
- R8: `valid_o` is high in exactly the cycle after a cycle with `req_i` high. `mask_o` and `none_o` update only on a request and otherwise hold their values.
- R9: `none_o` is 1 exactly when `mask_o` is zero.
- R10: While `rst_n` is low at a clock edge, the outputs are set to `valid_o`=0, `mask_o`=0 and `none_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe; the other inputs are sampled while it is high |
| dest_i | input | 8 | Destination field of the routing entry |
| logical_mode_i | input | 1 | 0 = physical identifier match, 1 = logical match |
| tgt_count_i | input | 4 | Number of populated target slots |
| tgt_phys_id_i | input | 64 | Physical identifier of each target, 8 bits per target, target i at [8i+7:8i] |
| tgt_ldr_i | input | 256 | Logical destination register of each target, 32 bits per target |
| tgt_dfr_i | input | 256 | Destination format register of each target, 32 bits per target |
| valid_o | output | 1 | One-cycle pulse that marks a new result |
| mask_o | output | 8 | Delivery mask, bit i selects target i |
| none_o | output | 1 | High when the mask is empty |

## Verification
The datapath holds no state other than the output register, so any logic fault shows up in the mask of the very next result and nowhere else. A wrong priority chain would set extra or higher-index bits in physical results. A bad present-slot decoder would let bits at or above the count through. A swapped nibble comparison would turn cluster hits into misses. Each of these is visible in the mask one cycle after the request that triggers it. A broken hold path shows up only on the idle cycle after a result, when the mask or the none flag changes without a request.

// File: rtl/dest_match_pkg.sv
// Package: shared sizes and codes for the destination mask generator.
// Assumes: identifiers are as wide as the destination field.
package dest_match_pkg;
    localparam int unsigned DM_DEST_W = 8;
    localparam int unsigned DM_REG_W  = 32;

    // Addressing model selected by bits [31:28] of a target's format register
    typedef enum logic [3:0] {
        FMT_CLUSTER = 4'h0,
        FMT_FLAT    = 4'hF
    } dm_fmt_e;

    // Per-target match result
    typedef struct packed {
        logic phys_hit;
        logic logic_hit;
    } dm_hit_t;
endpackage

// File: rtl/dm_present_decode.sv
// Module: turns the populated-slot count into a per-slot presence vector.
// Assumes: a count above N makes every slot present.
module dm_present_decode #(
    parameter int unsigned N     = 8,
    parameter int unsigned CNT_W = $clog2(N + 1)
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [N-1:0]     present_o
);
    // Slot i is present when its index lies below the count
    always_comb begin
        for (int i = 0; i < N; i++) begin
            present_o[i] = (32'(count_i) > 32'(i));
        end
    end
endmodule

// File: rtl/dm_target_match.sv
// Module: checks one target against the destination under both modes.
// Assumes: the logical field sits in bits [31:24] of the logical register and
// the model nibble sits in bits [31:28] of the format register.
module dm_target_match
    import dest_match_pkg::*;
(
    input  logic [DM_DEST_W-1:0] dest_i,
    input  logic                 present_i,
    input  logic [DM_DEST_W-1:0] phys_id_i,
    input  logic [DM_REG_W-1:0]  ldr_i,
    input  logic [DM_REG_W-1:0]  dfr_i,
    output dm_hit_t              hit_o
);
    logic [7:0] lfield;
    logic [3:0] model;
    logic       flat_hit;
    logic       clus_hit;

    // Extract the logical field and the addressing model
    always_comb begin
        lfield = ldr_i[31:24];
        model  = dfr_i[31:28];
    end

    // Evaluate each addressing model separately
    always_comb begin
        flat_hit = |(dest_i & lfield);
        clus_hit = (lfield[7:4] == dest_i[7:4]) && (|(lfield[3:0] & dest_i[3:0]));
    end

    // Combine with presence; unknown models never match
    always_comb begin
        hit_o.phys_hit = present_i && (phys_id_i == dest_i);
        unique case (model)
            FMT_FLAT:    hit_o.logic_hit = present_i && (dest_i != '0) && flat_hit;
            FMT_CLUSTER: hit_o.logic_hit = present_i && (dest_i != '0) && clus_hit;
            default:     hit_o.logic_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dm_first_hit.sv
// Module: keeps only the lowest-index set bit of a hit vector.
// Assumes: bit 0 has the highest precedence.
module dm_first_hit #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] hits_i,
    output logic [N-1:0] first_o
);
    logic [N:0] seen;

    // Ripple a "lower bit already taken" flag upward
    always_comb begin
        seen[0] = 1'b0;
        for (int i = 0; i < N; i++) begin
            first_o[i]  = hits_i[i] & ~seen[i];
            seen[i + 1] = seen[i] | hits_i[i];
        end
    end
endmodule

// File: rtl/dest_match_gen.sv
// Module: top of the destination mask generator. Registers mask, valid and
// none flag one cycle after a request.
// Assumes: inputs are stable in the cycle req_i is high; packed target
// buses place target i at slice i.
module dest_match_gen
    import dest_match_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter int unsigned CNT_W = $clog2(N + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [DM_DEST_W-1:0]    dest_i,
    input  logic                    logical_mode_i,
    input  logic [CNT_W-1:0]        tgt_count_i,
    input  logic [N*DM_DEST_W-1:0]  tgt_phys_id_i,
    input  logic [N*DM_REG_W-1:0]   tgt_ldr_i,
    input  logic [N*DM_REG_W-1:0]   tgt_dfr_i,
    output logic                    valid_o,
    output logic [N-1:0]            mask_o,
    output logic                    none_o
);
    logic [N-1:0] present;
    logic [N-1:0] phys_hits;
    logic [N-1:0] logic_hits;
    logic [N-1:0] phys_first;
    logic [N-1:0] mask_d;

    dm_present_decode #(.N(N), .CNT_W(CNT_W)) i_present (
        .count_i   (tgt_count_i),
        .present_o (present)
    );

    for (genvar g = 0; g < N; g++) begin : g_tgt
        dm_hit_t hit;
        dm_target_match i_match (
            .dest_i    (dest_i),
            .present_i (present[g]),
            .phys_id_i (tgt_phys_id_i[g*DM_DEST_W +: DM_DEST_W]),
            .ldr_i     (tgt_ldr_i[g*DM_REG_W +: DM_REG_W]),
            .dfr_i     (tgt_dfr_i[g*DM_REG_W +: DM_REG_W]),
            .hit_o     (hit)
        );
        assign phys_hits[g]  = hit.phys_hit;
        assign logic_hits[g] = hit.logic_hit;
    end

    dm_first_hit #(.N(N)) i_first (
        .hits_i  (phys_hits),
        .first_o (phys_first)
    );

    // Pick the mask of the requested mode
    always_comb begin
        mask_d = logical_mode_i ? logic_hits : phys_first;
    end

    // Capture the result on a request; hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            mask_o  <= '0;
            none_o  <= 1'b1;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                mask_o <= mask_d;
                none_o <= (mask_d == '0);
            end
        end
    end

    // R1
    phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !$past(logical_mode_i) |-> $onehot0(mask_o));
    // R2
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && $past(logical_mode_i) && ($past(dest_i) == '0) |-> (mask_o == '0));
    // R6
    absent_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((mask_o >> $past(tgt_count_i)) == '0));
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o && $stable(mask_o) && $stable(none_o));
    // R9
    none_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        none_o == (mask_o == '0));
endmodule

// File: tb/test_dest_match_gen.sv
module test_dest_match_gen;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_i;
    logic [7:0]    dest_i;
    logic          logical_mode_i;
    logic [3:0]    tgt_count_i;
    logic [N*8-1:0]  tgt_phys_id_i;
    logic [N*32-1:0] tgt_ldr_i;
    logic [N*32-1:0] tgt_dfr_i;
    logic          valid_o;
    logic [N-1:0]  mask_o;
    logic          none_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dest_match_gen i_dest_match_gen (
        .clk, .rst_n, .req_i, .dest_i, .logical_mode_i, .tgt_count_i,
        .tgt_phys_id_i, .tgt_ldr_i, .tgt_dfr_i, .valid_o, .mask_o, .none_o
    );

    function automatic logic [N-1:0] ref_mask();
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++) begin
            logic [7:0] id  = tgt_phys_id_i[i*8 +: 8];
            logic [7:0] lf  = tgt_ldr_i[i*32+24 +: 8];
            logic [3:0] fm  = tgt_dfr_i[i*32+28 +: 4];
            bit         hit = 0;
            if (i >= int'(tgt_count_i)) continue;
            if (!logical_mode_i) begin
                if (id == dest_i) begin
                    m[i] = 1'b1;
                    return m;
                end
            end else if (dest_i != 0) begin
                if (fm == 4'hF) hit = (dest_i & lf) != 0;
                else if (fm == 4'h0) hit = (lf[7:4] == dest_i[7:4]) && ((lf[3:0] & dest_i[3:0]) != 0);
                m[i] = hit;
            end
        end
        return m;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request and check the result and the following idle cycle
    task automatic run(string req);
        logic [N-1:0] exp;
        @(negedge clk);
        req_i = 1'b1;
        exp = ref_mask();
        @(negedge clk);
        req_i = 1'b0;
        check({req, " valid R8"}, 32'(valid_o), 1);
        check(req, 32'(mask_o), 32'(exp));
        check("R9", 32'(none_o), 32'(exp == 0));
        @(negedge clk);
        check("R8 hold", {22'(0), valid_o, mask_o, none_o}, {22'(0), 1'b0, exp, exp == 0});
    endtask

    task automatic set_tgt(int i, logic [7:0] id, logic [7:0] lf, logic [3:0] fm);
        tgt_phys_id_i[i*8 +: 8] = id;
        tgt_ldr_i[i*32 +: 32]   = {lf, 24'h0};
        tgt_dfr_i[i*32 +: 32]   = {fm, 28'hFFFFFFF};
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_i = 1'b1; dest_i = 8'h00; logical_mode_i = 1'b0;
        tgt_count_i = 4'd8; tgt_phys_id_i = '0; tgt_ldr_i = '0; tgt_dfr_i = '0;
        repeat (3) @(negedge clk);
        // R10 reset state even with a request pending
        check("R10", {29'(0), valid_o, 1'b0, none_o}, {29'(0), 1'b0, 1'b0, 1'b1});
        check("R10 mask", 32'(mask_o), 0);
        req_i = 1'b0;
        rst_n = 1'b1;

        // R1 physical, duplicates: lowest index wins
        for (int i = 0; i < N; i++) set_tgt(i, 8'(i), 8'h00, 4'hF);
        set_tgt(5, 8'h03, 8'h00, 4'hF);
        dest_i = 8'h03; tgt_count_i = 4'd8; logical_mode_i = 1'b0;
        run("R1");
        dest_i = 8'h77;
        run("R1 nomatch");
        // R6: count excludes matching slot
        dest_i = 8'h06; tgt_count_i = 4'd6;
        run("R6 phys");
        tgt_count_i = 4'd15; dest_i = 8'h07;
        run("R6 overcount");

        // Logical directed
        logical_mode_i = 1'b1; tgt_count_i = 4'd8;
        for (int i = 0; i < N; i++) set_tgt(i, 8'h00, 8'hFF, 4'hF);
        dest_i = 8'h00;
        run("R2");
        for (int i = 0; i < N; i++) set_tgt(i, 8'h00, 8'(1 << i), 4'hF);
        dest_i = 8'b0010_0101;
        run("R3 R5");
        set_tgt(0, 0, 8'h32, 4'h0); set_tgt(1, 0, 8'h21, 4'h0);
        set_tgt(2, 0, 8'h24, 4'h0); set_tgt(3, 0, 8'h38, 4'h0);
        set_tgt(4, 0, 8'h31, 4'h0); set_tgt(5, 0, 8'h34, 4'h5);
        set_tgt(6, 0, 8'hFF, 4'h8); set_tgt(7, 0, 8'h33, 4'h0);
        dest_i = 8'h33;
        run("R4 R7");
        tgt_count_i = 4'd4;
        run("R6 logical");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logical_mode_i = $urandom_range(0, 1);
            tgt_count_i = 4'($urandom_range(0, 9));
            dest_i = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
            for (int i = 0; i < N; i++) begin
                logic [3:0] fm;
                logic [7:0] lf = 8'($urandom);
                case ($urandom_range(0, 3))
                    0: fm = 4'hF;
                    1, 2: begin fm = 4'h0; if ($urandom_range(0, 1) == 1) lf[7:4] = dest_i[7:4]; end
                    default: fm = 4'($urandom_range(1, 14));
                endcase
                set_tgt(i, ($urandom_range(0, 1) == 1) ? dest_i : 8'($urandom_range(0, 15)), lf, fm);
            end
            run(logical_mode_i ? ((dest_i == 0) ? "R2" : "R5") : "R1");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule